// File: doc/BRIEF.md
# PLL Tuning Loop Digital Core

This block holds the clocked part of a frequency-synthesising tuning loop. Everything runs on the reference clock `clk_i`. A reference divider produces a comparison event once every 512 or 1024 reference cycles. The oscillator arrives as a strobe `osc_tick_i`, already synchronised, with one pulse per oscillator cycle. It first passes a divide-by-8 prescaler and then a 15-bit programmable divider with ratio N. When the loop is locked, the oscillator therefore runs at N x 8 times the comparison rate.

A two-flop phase-frequency detector turns the two divided events into pump-up and pump-down requests for an external analog pump. A lock detector watches the width of those requests. Control levels from the register interface set the following:
- the pump current level;
- pump disable;
- drive-amplifier disable;
- the reference ratio;
- a small set of test codes.

The test codes either force the pump direction together with the reported lock flag, or route the divided signals onto the override outputs for ports P7 and P6.

Top module: `synth_loop_core`

## Requirements
- R1: After reset, both pump requests are 0, `lock_o` is 0, both port overrides are inactive, `drive_en_o` equals the inverse of `drive_off_i`, and `cur_hi_o` equals `cp_i`.
- R2: The comparison period is 512 reference cycles when the latched ratio bit is 1 and 1024 cycles when it is 0. The latched bit resets to 0. With `test_en_i`=1 and `mode_i`=3'b111, `p7_ovr_o` carries a square wave of that period.
- R3: The ratio bit is copied from `mode_i[0]` only while `test_en_i`=0. Every code applied with `test_en_i`=1 leaves it unchanged.
- R4: With `test_en_i`=1 and `mode_i`=3'b111, `p6_ovr_en_o`=1 and `p6_ovr_o` gives one single-cycle pulse per 8 x N oscillator ticks, where N=`ratio_i`.
- R5: A new `ratio_i` value takes effect only at the divider's next terminal count. The interval in progress keeps the old N.
- R6: With `test_en_i`=1 and `mode_i`=3'b101, `p7_ovr_o` toggles once per divided-oscillator pulse, giving a period of 2 x 8 x N ticks, and `p6_ovr_en_o`=0.
- R7: With `test_en_i`=1 and `mode_i`=3'b001, `pump_dn_o`=1, `pump_up_o`=0 and `lock_o`=0.
- R8: With `test_en_i`=1 and `mode_i`=3'b011, `pump_up_o`=1, `pump_dn_o`=0 and `lock_o`=1. At all times `cur_hi_o` = `cp_i` AND NOT `lock_o`.
- R9: `pump_off_i`=1 holds both pump requests at 0 in every mode, forced modes included.
- R10: `drive_off_i`=1 drives `drive_en_o` to 0.
- R11: `lock_o` rises only on a comparison event that closes the 4th consecutive comparison period in which no up or down request lasted 2 or more cycles.
- R12: An up or down request lasting 2 or more consecutive cycles clears the lock flag on the next cycle.
- R13: With `test_en_i`=1 and any code other than 001, 011, 101 or 111, both overrides are inactive and the pump requests come from the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator cycle |
| ratio_i | input | 15 | Programmable divider ratio N |
| cp_i | input | 1 | High pump current request |
| pump_off_i | input | 1 | Disable both pump requests |
| test_en_i | input | 1 | Test code enable |
| mode_i | input | 3 | Test code; bit 0 is the ratio select in normal mode |
| drive_off_i | input | 1 | Switch the drive amplifier off |
| pump_up_o | output | 1 | Pump sink (raise frequency) request |
| pump_dn_o | output | 1 | Pump source (lower frequency) request |
| cur_hi_o | output | 1 | High pump current select |
| drive_en_o | output | 1 | Drive amplifier enable |
| lock_o | output | 1 | Reported lock flag |
| p7_ovr_en_o | output | 1 | Port P7 override active |
| p7_ovr_o | output | 1 | Port P7 override value |
| p6_ovr_en_o | output | 1 | Port P6 override active |
| p6_ovr_o | output | 1 | Port P6 override value |

## Verification
The divider states can only be seen through the test routes, so any miscount appears as a wrong period on the P7 or P6 override. Such an error shows within one or two periods of the programmed ratio.

A wrong latched ratio bit shows as a period that doubles or halves as soon as the square wave is routed out.

Lock-detector faults show up in a closed loop. The bench models an oscillator that stalls while pump-down is asserted. Within a few comparison periods, a faulty detector either fails to assert `lock_o` after the phases align or fails to drop it after N is mistuned. The same fault also appears as a wrong `cur_hi_o` level.

// File: rtl/synth_loop_pkg.sv
package synth_loop_pkg;
  localparam int unsigned REF_LO    = 512;
  localparam int unsigned REF_HI    = 1024;
  localparam int unsigned RATIO_W   = 15;
  localparam int unsigned PRE_DIV   = 8;
  localparam int unsigned LOCK_CNT  = 4;
  localparam int unsigned WIDE_LIM  = 2;

  typedef enum logic [2:0] {
    CODE_FRC_DN  = 3'b001,
    CODE_FRC_UP  = 3'b011,
    CODE_FB_HALF = 3'b101,
    CODE_DIV_OUT = 3'b111
  } test_code_e;
endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
  parameter int unsigned REF_LO = 512,
  parameter int unsigned REF_HI = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_lo_i,
  output logic cmp_o,
  output logic cmp_sq_o
);
  localparam int unsigned CNT_W  = $clog2(REF_HI);
  localparam int unsigned LO_MSB = $clog2(REF_LO) - 1;
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(REF_LO - 1);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(REF_HI - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  assign lim  = sel_lo_i ? LIM_LO : LIM_HI;
  assign wrap = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_o <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      cmp_o <= wrap;
    end
  end

  assign cmp_sq_o = sel_lo_i ? cnt_q[LO_MSB] : cnt_q[CNT_W-1];

  // R2
  cmp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_o |=> !cmp_o);
endmodule

// File: rtl/synth_fb_div.sv
module synth_fb_div #(
  parameter int unsigned RATIO_W = 15,
  parameter int unsigned PRE_DIV = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               fb_o,
  output logic               fb_half_o
);
  localparam int unsigned PRE_W = $clog2(PRE_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0]   pre_q;
  logic [RATIO_W-1:0] n_q;
  logic               pre_tc;
  logic               n_tc;

  assign pre_tc = tick_i && (pre_q == PRE_LAST);
  assign n_tc   = pre_tc && (n_q <= RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      n_q       <= '0;
      fb_o      <= 1'b0;
      fb_half_o <= 1'b0;
    end else begin
      if (tick_i) pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (pre_tc) n_q <= n_tc ? ratio_i : n_q - 1'b1;
      fb_o <= n_tc;
      if (n_tc) fb_half_o <= ~fb_half_o;
    end
  end

  // R4
  fb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_o |=> !fb_o);
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_o,
  output logic dn_o
);
  logic up_n, dn_n;

  assign up_n = up_o | ref_i;
  assign dn_n = dn_o | fb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else if (up_n && dn_n) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_n;
      dn_o <= dn_n;
    end
  end

  // R11
  up_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && fb_i) |=> !up_o);
endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
  parameter int unsigned LOCK_CNT = 4,
  parameter int unsigned WIDE_LIM = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic up_i,
  input  logic dn_i,
  output logic lock_o
);
  localparam int unsigned RUN_W = $clog2(WIDE_LIM) + 1;
  localparam int unsigned CNT_W = $clog2(LOCK_CNT) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(WIDE_LIM - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CNT - 1);

  logic [RUN_W-1:0] up_run_q, dn_run_q;
  logic [CNT_W-1:0] good_q;
  logic             seen_q;
  logic             wide;

  assign wide = (up_i && up_run_q >= RUN_MAX) || (dn_i && dn_run_q >= RUN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_run_q <= '0;
      dn_run_q <= '0;
      good_q   <= '0;
      seen_q   <= 1'b0;
      lock_o   <= 1'b0;
    end else begin
      up_run_q <= !up_i ? '0 : (up_run_q >= RUN_MAX) ? RUN_MAX : up_run_q + 1'b1;
      dn_run_q <= !dn_i ? '0 : (dn_run_q >= RUN_MAX) ? RUN_MAX : dn_run_q + 1'b1;
      if (wide) begin
        lock_o <= 1'b0;
        good_q <= '0;
        seen_q <= 1'b1;
      end else if (cmp_i) begin
        seen_q <= 1'b0;
        if (!seen_q) begin
          if (good_q >= CNT_LAST) lock_o <= 1'b1;
          else                    good_q <= good_q + 1'b1;
        end
      end
    end
  end

  // R11
  lock_on_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(cmp_i));
  // R12
  wide_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide |=> !lock_o);
endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core
  import synth_loop_pkg::*;
#(
  parameter int unsigned P_REF_LO   = REF_LO,
  parameter int unsigned P_REF_HI   = REF_HI,
  parameter int unsigned P_RATIO_W  = RATIO_W,
  parameter int unsigned P_PRE_DIV  = PRE_DIV,
  parameter int unsigned P_LOCK_CNT = LOCK_CNT,
  parameter int unsigned P_WIDE_LIM = WIDE_LIM
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 osc_tick_i,
  input  logic [P_RATIO_W-1:0] ratio_i,
  input  logic                 cp_i,
  input  logic                 pump_off_i,
  input  logic                 test_en_i,
  input  logic [2:0]           mode_i,
  input  logic                 drive_off_i,
  output logic                 pump_up_o,
  output logic                 pump_dn_o,
  output logic                 cur_hi_o,
  output logic                 drive_en_o,
  output logic                 lock_o,
  output logic                 p7_ovr_en_o,
  output logic                 p7_ovr_o,
  output logic                 p6_ovr_en_o,
  output logic                 p6_ovr_o
);
  logic sel_lo_q;
  logic cmp, cmp_sq, fb, fb_half;
  logic pfd_up, pfd_dn, det_lock;
  logic frc_dn, frc_up, rt_half, rt_div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sel_lo_q <= 1'b0;
    else if (!test_en_i) sel_lo_q <= mode_i[0];
  end

  synth_ref_div #(.REF_LO(P_REF_LO), .REF_HI(P_REF_HI)) u_ref (
    .clk_i, .rst_ni, .sel_lo_i(sel_lo_q), .cmp_o(cmp), .cmp_sq_o(cmp_sq));

  synth_fb_div #(.RATIO_W(P_RATIO_W), .PRE_DIV(P_PRE_DIV)) u_fb (
    .clk_i, .rst_ni, .tick_i(osc_tick_i), .ratio_i,
    .fb_o(fb), .fb_half_o(fb_half));

  synth_pfd u_pfd (
    .clk_i, .rst_ni, .ref_i(cmp), .fb_i(fb), .up_o(pfd_up), .dn_o(pfd_dn));

  synth_lock_det #(.LOCK_CNT(P_LOCK_CNT), .WIDE_LIM(P_WIDE_LIM)) u_lock (
    .clk_i, .rst_ni, .cmp_i(cmp), .up_i(pfd_up), .dn_i(pfd_dn), .lock_o(det_lock));

  assign frc_dn  = test_en_i && (mode_i == CODE_FRC_DN);
  assign frc_up  = test_en_i && (mode_i == CODE_FRC_UP);
  assign rt_half = test_en_i && (mode_i == CODE_FB_HALF);
  assign rt_div  = test_en_i && (mode_i == CODE_DIV_OUT);

  always_comb begin
    pump_up_o = 1'b0;
    pump_dn_o = 1'b0;
    if (!pump_off_i) begin
      if (frc_up)      pump_up_o = 1'b1;
      else if (frc_dn) pump_dn_o = 1'b1;
      else begin
        pump_up_o = pfd_up;
        pump_dn_o = pfd_dn;
      end
    end
  end

  assign lock_o      = frc_up | (!frc_dn & det_lock);
  assign cur_hi_o    = cp_i & ~lock_o;
  assign drive_en_o  = ~drive_off_i;
  assign p7_ovr_en_o = rt_half | rt_div;
  assign p7_ovr_o    = rt_div ? cmp_sq : (rt_half & fb_half);
  assign p6_ovr_en_o = rt_div;
  assign p6_ovr_o    = rt_div & fb;

  // R3
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_en_i |=> $stable(sel_lo_q));
endmodule

// File: tb/synth_loop_core_test.sv
module synth_loop_core_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic [14:0] ratio = 15'd5;
  logic        cp = 1'b1, pump_off = 1'b0, test_en = 1'b0, drive_off = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic        pump_up, pump_dn, cur_hi, drive_en, lock;
  logic        p7_en, p7_v, p6_en, p6_v;
  bit          osc_run = 1'b0;
  bit          done = 1'b0;
  int          n_tests = 0, n_fail = 0;

  typedef struct { string tag; int val; } exp_t;
  exp_t exp_q[$];
  int   act_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_loop_core uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc_tick), .ratio_i(ratio),
    .cp_i(cp), .pump_off_i(pump_off), .test_en_i(test_en), .mode_i(mode),
    .drive_off_i(drive_off), .pump_up_o(pump_up), .pump_dn_o(pump_dn),
    .cur_hi_o(cur_hi), .drive_en_o(drive_en), .lock_o(lock),
    .p7_ovr_en_o(p7_en), .p7_ovr_o(p7_v), .p6_ovr_en_o(p6_en), .p6_ovr_o(p6_v));

  // oscillator model: stalls while pump-down is requested
  always @(negedge clk) osc_tick <= osc_run && !pump_dn;

  // monitor: pops expected and actual items and compares them
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      exp_t e;
      int   a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_tests++;
      if (a != e.val) begin
        n_fail++;
        $display("FAIL %s actual=%0d expected=%0d", e.tag, a, e.val);
      end
    end
  end

  task automatic push(input string tag, input int act, input int exp);
    exp_q.push_back('{tag, exp});
    act_q.push_back(act);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic sig(input int sel);
    return (sel == 0) ? p7_v : p6_v;
  endfunction

  // cycles between consecutive rising edges of the chosen override value
  task automatic period(input int sel, output int per);
    logic prev;
    prev = sig(sel);
    forever begin
      @(negedge clk);
      if (sig(sel) && !prev) break;
      prev = sig(sel);
    end
    per = 0;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      per++;
      if (sig(sel) && !prev) break;
      prev = sig(sel);
    end
  endtask

  initial begin
    int p, t;
    cyc(3);
    push("R1 up", pump_up, 0); push("R1 dn", pump_dn, 0);
    push("R1 lock", lock, 0);  push("R1 p7en", p7_en, 0);
    push("R1 p6en", p6_en, 0);
    rst_n = 1'b1;
    cyc(1);
    push("R1 drive", drive_en, 1); push("R1 cur", cur_hi, 1);

    // no oscillator: up request stays high; unlisted code keeps detector path
    cyc(3200);
    test_en = 1'b1; mode = 3'b110; cyc(2);
    push("R13 up", pump_up, 1); push("R13 dn", pump_dn, 0);
    push("R13 p7en", p7_en, 0); push("R13 p6en", p6_en, 0);

    drive_off = 1'b1; cyc(1);
    push("R10 drive", drive_en, 0);
    drive_off = 1'b0;

    mode = 3'b001; cyc(1);
    push("R7 dn", pump_dn, 1); push("R7 up", pump_up, 0); push("R7 lock", lock, 0);
    mode = 3'b011; cyc(1);
    push("R8 up", pump_up, 1); push("R8 dn", pump_dn, 0);
    push("R8 lock", lock, 1); push("R8 cur", cur_hi, 0);
    pump_off = 1'b1; cyc(1);
    push("R9 up", pump_up, 0); push("R9 dn", pump_dn, 0);
    mode = 3'b001; cyc(1);
    push("R9 dn forced", pump_dn, 0);

    // ratio bit reset value is 0 -> 1024
    mode = 3'b111; cyc(1100);
    period(0, p); push("R2 ratio1024", p, 1024);
    push("R4 p6en", p6_en, 1);
    test_en = 1'b0; mode = 3'b001; cyc(4);
    test_en = 1'b1; mode = 3'b111; cyc(1100);
    period(0, p); push("R2 ratio512", p, 512);
    mode = 3'b110; cyc(20); mode = 3'b000; cyc(20);
    mode = 3'b111; cyc(1100);
    period(0, p); push("R3 ratio kept", p, 512);

    // divider route, pump disabled so the oscillator ticks every cycle
    osc_run = 1'b1; ratio = 15'd5; cyc(200);
    period(1, p); push("R4 n5", p, 40);
    ratio = 15'd9; cyc(200);
    period(1, p); push("R4 n9", p, 72);
    ratio = 15'd5; cyc(200);
    period(1, p);
    cyc(2); ratio = 15'd3;
    t = 2;
    while (!p6_v) begin @(negedge clk); t++; end
    push("R5 old interval", t, 40);
    period(1, p); push("R5 new interval", p, 24);

    ratio = 15'd5; mode = 3'b101; cyc(200);
    period(0, p); push("R6 half", p, 80);
    push("R6 p6en", p6_en, 0);

    // closed loop at /512: N=56 runs fast, then N=64 aligns
    test_en = 1'b0; mode = 3'b001; pump_off = 1'b0; ratio = 15'd56;
    cyc(12 * 512);
    push("R11 unlocked", lock, 0); push("R11 cur unlocked", cur_hi, 1);
    ratio = 15'd64;
    cyc(16 * 512);
    push("R11 locked", lock, 1); push("R8 cur locked", cur_hi, 0);
    ratio = 15'd70;
    cyc(3 * 512);
    push("R12 lost", lock, 0); push("R12 cur", cur_hi, 1);

    cyc(4);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule